// File: doc/BRIEF.md
# Tick-and-Residue Elapsed Time Stamper

This block turns a coarse periodic wrap event and a fine residual down-count into one high-resolution timestamp. A tick counter advances by one on every wrap pulse from an external periodic down-counter. The downcounts already consumed in the current period, which is the period length minus the live remaining count, form the low-order part of the stamp. With a full 16-bit period (load value zero, 65536 downcounts per tick), the stamp is simply the tick count in the upper bits and the consumed downcounts in the lower 16 bits.

Two capture strobes, start and stop, each snapshot the tick count and the remaining count in the same clock edge. A wrap that lands between two separate reads therefore cannot tear the stamp. The block presents both snapshots and their difference modulo 2^(TICK_W+16). The difference is correct even when the stop's fine part is smaller than the start's, which happens when the fine component borrows from the whole ticks. The tick counter wraps silently.

Top module: `elapsed_stamper`

## Requirements
- R1: While reset is asserted (rst_n low, active low, asynchronous), the tick count, the start stamp, the stop stamp and the elapsed output are all zero.
- R2: Each rising clock edge with wrap_i high increments the tick count by exactly one. An edge with wrap_i low leaves the tick count unchanged.
- R3: live_o[15:0] equals (65536 - remain_i) mod 65536, so a remaining count of 0 (a full period) reads as 0 consumed.
- R4: live_o[SW-1:16] equals the tick count plus one if wrap_i is high in that cycle, and the tick count otherwise.
- R5: An edge with start_i high loads start_o with the value live_o had before that edge. Otherwise start_o holds its value.
- R6: An edge with stop_i high loads stop_o with the value live_o had before that edge. Otherwise stop_o holds its value.
- R7: elapsed_o equals stop_o minus start_o modulo 2^SW. This holds when the stop's fine field is below the start's fine field.
- R8: A capture on the same edge as a wrap with remain_i = 0 stores the incremented tick count with a fine field of 0.
- R9: Start and stop strobes on the same edge capture identical stamps, so elapsed_o becomes 0.
- R10: The tick count wraps from 2^TICK_W-1 to 0 with no other effect, and elapsed_o across that wrap is still the modular difference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrap_i | input | 1 | One-cycle pulse when the periodic down-counter wraps |
| remain_i | input | CNT_W | Live remaining count of the down-counter |
| start_i | input | 1 | Capture strobe for the start stamp |
| stop_i | input | 1 | Capture strobe for the stop stamp |
| live_o | output | SW | Current combined stamp {tick, consumed} |
| start_o | output | SW | Start snapshot |
| stop_o | output | SW | Stop snapshot |
| elapsed_o | output | SW | stop_o minus start_o modulo 2^SW |

## Verification
The assertions check on every cycle that the tick steps by exactly one per wrap and holds otherwise. They also check that each snapshot register either takes the prior live stamp or holds, that the fine field and remaining count sum to zero modulo 65536, and that a same-edge start and stop gives zero elapsed time. Only the bench scenarios can show the end-to-end values. These are a borrow between fine and coarse parts, a capture coinciding with a wrap at a full-period residue, the silent tick rollover, and a difference spanning that rollover. The bench uses an 8-bit tick count so that the rollover is reached.

// File: rtl/elapsed_stamper.sv
module elapsed_stamper #(
  parameter  int TICK_W = 32,
  parameter  int CNT_W  = 16,
  localparam int SW     = TICK_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] remain_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic [SW-1:0]    live_o,
  output logic [SW-1:0]    start_o,
  output logic [SW-1:0]    stop_o,
  output logic [SW-1:0]    elapsed_o
);

  logic [TICK_W-1:0] tick_q;
  logic [TICK_W-1:0] tick_nx;
  logic [CNT_W-1:0]  used;
  logic [SW-1:0]     start_q;
  logic [SW-1:0]     stop_q;

  // a wrap on the capture edge belongs to the new tick
  assign tick_nx = tick_q + TICK_W'(wrap_i);
  assign used    = CNT_W'(0) - remain_i;
  assign live_o  = {tick_nx, used};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q  <= '0;
      start_q <= '0;
      stop_q  <= '0;
    end else begin
      if (wrap_i)  tick_q  <= tick_nx;
      if (start_i) start_q <= live_o;
      if (stop_i)  stop_q  <= live_o;
    end
  end

  assign start_o   = start_q;
  assign stop_o    = stop_q;
  assign elapsed_o = stop_q - start_q;

endmodule

// File: rtl/elapsed_stamper_chk.sv
module elapsed_stamper_chk #(
  parameter int TICK_W = 32,
  parameter int CNT_W  = 16,
  parameter int SW     = TICK_W + CNT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrap_i,
  input logic [CNT_W-1:0]  remain_i,
  input logic              start_i,
  input logic              stop_i,
  input logic [TICK_W-1:0] tick_q,
  input logic [SW-1:0]     live_o,
  input logic [SW-1:0]     start_o,
  input logic [SW-1:0]     stop_o,
  input logic [SW-1:0]     elapsed_o
);

  logic [CNT_W-1:0] fine_sum;
  assign fine_sum = live_o[CNT_W-1:0] + remain_i;

  always_comb begin
    if (rst_n) begin
      AST_FINE_COMPLEMENT: assert (fine_sum == '0); // R3
    end
  end

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> tick_q == $past(tick_q) + TICK_W'(1)); // R2
  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(tick_q)); // R2
  AST_START_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> start_o == $past(live_o)); // R5
  AST_START_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(start_o)); // R5
  AST_STOP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> stop_o == $past(live_o)); // R6
  AST_STOP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_i |=> $stable(stop_o)); // R6
  AST_SAME_EDGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && stop_i) |=> elapsed_o == '0); // R9

endmodule

bind elapsed_stamper elapsed_stamper_chk #(.TICK_W(TICK_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrap_i(wrap_i), .remain_i(remain_i),
  .start_i(start_i), .stop_i(stop_i), .tick_q(tick_q), .live_o(live_o),
  .start_o(start_o), .stop_o(stop_o), .elapsed_o(elapsed_o)
);

// File: tb/tb_elapsed_stamper.sv
`timescale 1ns/1ps
module tb_elapsed_stamper;
  localparam int TW = 8;
  localparam int CW = 16;
  localparam int SW = TW + CW;

  typedef struct {
    logic [SW-1:0] live;
    logic [SW-1:0] st;
    logic [SW-1:0] sp;
    logic [SW-1:0] el;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrap = 1'b0;
  logic [CW-1:0] remain = '0;
  logic start = 1'b0;
  logic stop = 1'b0;
  logic [SW-1:0] live_o, start_o, stop_o, elapsed_o;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];

  logic [TW-1:0] m_tick = '0;
  logic [SW-1:0] m_start = '0;
  logic [SW-1:0] m_stop  = '0;

  always #10 clk = ~clk;

  elapsed_stamper #(.TICK_W(TW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .remain_i(remain),
    .start_i(start), .stop_i(stop), .live_o(live_o), .start_o(start_o),
    .stop_o(stop_o), .elapsed_o(elapsed_o)
  );

  task automatic cmp(input string tag, input string what,
                     input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [CW-1:0] r,
                      input logic s, input logic p, input string tag);
    logic [TW-1:0] t1;
    logic [CW-1:0] fn;
    logic [SW-1:0] now;
    exp_t e;
    @(negedge clk);
    wrap = w; remain = r; start = s; stop = p;
    t1  = m_tick + TW'(w);
    fn  = CW'(0) - r;
    now = {t1, fn};
    if (s) m_start = now;
    if (p) m_stop  = now;
    m_tick = t1;
    e.live = {m_tick + TW'(w), fn};
    e.st   = m_start;
    e.sp   = m_stop;
    e.el   = m_stop - m_start;
    e.tag  = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        cmp(e.tag, "live",    live_o,    e.live);
        cmp(e.tag, "start",   start_o,   e.st);
        cmp(e.tag, "stop",    stop_o,    e.sp);
        cmp(e.tag, "elapsed", elapsed_o, e.el);
      end
    end
  end

  initial begin : watchdog
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : driver
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    remain = 16'h1234; wrap = 1'b1; start = 1'b1; stop = 1'b1;
    #1;
    cmp("R1", "start in reset", start_o, '0);
    cmp("R1", "stop in reset", stop_o, '0);
    cmp("R1", "elapsed in reset", elapsed_o, '0);
    cmp("R1", "tick in reset", {live_o[SW-1:CW], 16'h0}, {8'h01, 16'h0});
    wrap = 0; start = 0; stop = 0; remain = '0;
    rst_n = 1'b1;

    step(0, 16'd0,     0, 0, "R3 full-period residue");
    step(0, 16'd1,     0, 0, "R3 one left");
    step(0, 16'hFFFF,  0, 0, "R3 one consumed");
    step(0, 16'd40000, 0, 0, "R3 mid period");
    step(1, 16'd5,     0, 0, "R2 R4 wrap");
    step(1, 16'd0,     0, 0, "R2 R4 wrap");
    step(0, 16'd700,   0, 0, "R2 hold");
    step(1, 16'd0,     0, 0, "R2 wrap");

    step(0, 16'd35000, 1, 0, "R5 start capture");
    step(0, 16'd30000, 0, 0, "R5 start hold");
    step(1, 16'd0,     0, 0, "R2");
    step(1, 16'd0,     0, 0, "R2");
    step(0, 16'd43000, 0, 1, "R6 R7 stop with borrow");
    step(0, 16'd100,   0, 0, "R6 R7 hold");

    step(1, 16'd0,     1, 0, "R8 start on wrap");
    step(0, 16'd9,     0, 0, "R8 hold");
    step(1, 16'd0,     0, 1, "R8 stop on wrap");
    step(0, 16'd3,     1, 1, "R9 same edge");
    step(1, 16'd0,     1, 1, "R9 same edge on wrap");

    lfsr = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr, lfsr[3] & lfsr[5], lfsr[7] & lfsr[9], "R7 mixed");
    end

    step(0, 16'd20000, 1, 0, "R10 start before rollover");
    for (int i = 0; i < 300; i++) step(1, 16'd0, 0, 0, "R10 tick rollover");
    step(0, 16'd50000, 0, 1, "R10 stop after rollover");
    step(0, 16'd50000, 0, 0, "R10 hold");

    @(negedge clk);
    wrap = 0; start = 0; stop = 0;
    repeat (3) @(posedge clk);
    #6;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule